// File: doc/BRIEF.md
# Multi-Register Compare-Match Timer Channel

This block is one channel of a general-purpose timer. It has a 16-bit up-counter that advances on a clock-enable strobe and wraps to zero after its top value. The counter is compared every cycle against eight compare registers. The first four registers each own an output pin, and each has a two-bit action code that says what a match does to that pin. The other four registers have no pin, but they still compare, raise flags, request interrupts and fire triggers.

Every match latches a sticky flag. Software clears a flag by writing a one to it. Each flag can be routed to the interrupt request line through its own enable bit. Each register can also send a one-cycle trigger pulse toward a neighbouring channel through its own enable bit. A pin can be taken out of compare control and driven from a software data bit instead. The channel can therefore serve matches by polling or by interrupt with no pin activity.

Software reaches the channel through a flat register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `match_timer`

## Requirements
- R1: The counter (address 0) increments by one on each clock edge where `cnt_en` is high and wraps from 0xFFFF to 0x0000. A write to address 0 loads the counter, and a write wins over an increment in the same cycle.
- R2: A match is a cycle in which `cnt_en` is high and the counter equals a compare register (register i at address 8+i). On the edge that ends that cycle, the output level of pinned register i (i = 0..3) follows its action code at address 6, bits [2i+1:2i]: 00 leaves it unchanged, 01 clears it, 10 sets it, 11 inverts it.
- R3: A match on register i sets bit i of the flag word (address 1) on the same edge. The bit stays set until software writes a 1 to it. Writing 0 to a bit has no effect.
- R4: If a match on register i and a write-1 clear of bit i fall in the same cycle, the bit ends up set.
- R5: `irq` is high exactly when some flag bit i is set and bit i of the interrupt-enable word (address 2) is set.
- R6: A match on register i with bit i of the trigger-enable word (address 3) set drives `trig` high for the one cycle after the matching edge. A match on a register whose enable is clear produces no pulse.
- R7: Registers 4..7 have no pin. They compare and flag whatever their action codes are, and their matches never change `pin_out`.
- R8: When bit i of the pin-mode word (address 4) is 1, `pin_out[i]` shows the compare-driven level. When it is 0, `pin_out[i]` shows bit i of the pin-data word (address 5). The compare-driven level and the flags keep updating in either mode.
- R9: After reset the counter, flags, enables, modes, pin data, action codes and compare registers read zero, and `pin_out`, `irq` and `trig` are low.
- R10: While `cnt_en` is low, the counter holds and no match occurs, even when it equals a compare register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Counter advance strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| pin_out | output | 4 | Compare output pins |
| irq | output | 1 | Interrupt request |
| trig | output | 1 | Trigger pulse to the neighbouring channel |

## Verification
A wrong pin level does not show at the time it goes wrong. It shows on `pin_out` only when that pin is in compare mode. After a wrong toggle it stays inverted until the next match on that register, so the bench reads the pin right after every matching edge. A flag that sets late or clears wrongly is visible on the read port and on `irq` one cycle after the matching edge. A trigger that is gated wrongly shows only in that single cycle, so the bench samples `trig` both in the cycle after the match and in the cycle after that.

// File: rtl/mt_pkg.sv
package mt_pkg;
   // register addresses
   localparam int ADR_CNT  = 0;
   localparam int ADR_FLG  = 1;
   localparam int ADR_IEN  = 2;
   localparam int ADR_TEN  = 3;
   localparam int ADR_MOD  = 4;
   localparam int ADR_GPO  = 5;
   localparam int ADR_ACT  = 6;
   localparam int ADR_CMP0 = 8;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'b00,
      ACT_LOW    = 2'b01,
      ACT_HIGH   = 2'b10,
      ACT_TOGGLE = 2'b11
   } act_e;

   function automatic logic next_level(act_e a, logic cur);
      case (a)
         ACT_LOW:    next_level = 1'b0;
         ACT_HIGH:   next_level = 1'b1;
         ACT_TOGGLE: next_level = ~cur;
         default:    next_level = cur;
      endcase
   endfunction
endpackage

// File: rtl/mt_counter.sv
module mt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (ld)
         cnt <= ld_val;
      else if (en)
         cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/mt_slot.sv
module mt_slot #(
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             cnt_en,
   output logic             hit
);
   // one match per count value: only while the counter is about to move on
   assign hit = cnt_en && (cnt == cmp_val);
endmodule

// File: rtl/mt_pin.sv
module mt_pin (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hit,
   input  logic [1:0] act,
   output logic       level
);
   import mt_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         level <= 1'b0;
      else if (hit)
         level <= next_level(act_e'(act), level);
   end
endmodule

// File: rtl/mt_regbank.sv
module mt_regbank #(
   parameter int CNT_W  = 16,
   parameter int N_PIN  = 4,
   parameter int N_ALL  = 8,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [DATA_W-1:0]           wdata,
   input  logic [CNT_W-1:0]            cnt,
   input  logic [N_ALL-1:0]            hit,
   output logic [DATA_W-1:0]           rdata,
   output logic                        cnt_ld,
   output logic [N_ALL-1:0][CNT_W-1:0] cmp,
   output logic [N_ALL-1:0]            flags,
   output logic [N_ALL-1:0]            ien,
   output logic [N_ALL-1:0]            ten,
   output logic [N_PIN-1:0]            mode,
   output logic [N_PIN-1:0]            gpo,
   output logic [N_ALL-1:0][1:0]       act
);
   import mt_pkg::*;

   localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(ADR_CNT);
   localparam logic [ADDR_W-1:0] A_FLG  = ADDR_W'(ADR_FLG);
   localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(ADR_IEN);
   localparam logic [ADDR_W-1:0] A_TEN  = ADDR_W'(ADR_TEN);
   localparam logic [ADDR_W-1:0] A_MOD  = ADDR_W'(ADR_MOD);
   localparam logic [ADDR_W-1:0] A_GPO  = ADDR_W'(ADR_GPO);
   localparam logic [ADDR_W-1:0] A_ACT  = ADDR_W'(ADR_ACT);
   localparam logic [ADDR_W-1:0] A_CMP0 = ADDR_W'(ADR_CMP0);

   logic [N_ALL-1:0] clr;

   assign cnt_ld = wr && (addr == A_CNT);
   assign clr    = (wr && addr == A_FLG) ? wdata[N_ALL-1:0] : '0;

   // flags: a match wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags <= '0;
      else
         flags <= (flags & ~clr) | hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien  <= '0;
         ten  <= '0;
         mode <= '0;
         gpo  <= '0;
         act  <= '0;
      end else if (wr) begin
         if (addr == A_IEN) ien  <= wdata[N_ALL-1:0];
         if (addr == A_TEN) ten  <= wdata[N_ALL-1:0];
         if (addr == A_MOD) mode <= wdata[N_PIN-1:0];
         if (addr == A_GPO) gpo  <= wdata[N_PIN-1:0];
         if (addr == A_ACT) act  <= wdata[2*N_ALL-1:0];
      end
   end

   for (genvar i = 0; i < N_ALL; i++) begin : g_cmp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cmp[i] <= '0;
         else if (wr && addr == A_CMP0 + ADDR_W'(i))
            cmp[i] <= wdata[CNT_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_CNT:   rdata = DATA_W'(cnt);
         A_FLG:   rdata = DATA_W'(flags);
         A_IEN:   rdata = DATA_W'(ien);
         A_TEN:   rdata = DATA_W'(ten);
         A_MOD:   rdata = DATA_W'(mode);
         A_GPO:   rdata = DATA_W'(gpo);
         A_ACT:   rdata = DATA_W'(act);
         default: rdata = '0;
      endcase
      for (int i = 0; i < N_ALL; i++)
         if (addr == A_CMP0 + ADDR_W'(i))
            rdata = DATA_W'(cmp[i]);
   end
endmodule

// File: rtl/match_timer.sv
module match_timer #(
   parameter int CNT_W  = 16,
   parameter int N_PIN  = 4,
   parameter int N_CMP  = 4,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [N_PIN-1:0]  pin_out,
   output logic              irq,
   output logic              trig
);
   localparam int N_ALL = N_PIN + N_CMP;

   if (DATA_W < CNT_W)
      $error("match_timer: DATA_W must hold the counter");
   if (DATA_W < 2 * N_ALL)
      $error("match_timer: DATA_W must hold all action codes");
   if (mt_pkg::ADR_CMP0 + N_ALL > (1 << ADDR_W))
      $error("match_timer: ADDR_W too small for compare registers");
   if (N_PIN < 1)
      $error("match_timer: at least one pinned register is required");

   logic [CNT_W-1:0]            cnt;
   logic                        cnt_ld;
   logic [N_ALL-1:0]            hit;
   logic [N_ALL-1:0][CNT_W-1:0] cmp;
   logic [N_ALL-1:0]            flags;
   logic [N_ALL-1:0]            ien;
   logic [N_ALL-1:0]            ten;
   logic [N_PIN-1:0]            mode;
   logic [N_PIN-1:0]            gpo;
   logic [N_ALL-1:0][1:0]       act;
   logic [N_PIN-1:0]            level;
   logic                        trig_q;

   mt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (cnt_en),
      .ld     (cnt_ld),
      .ld_val (bus_wdata[CNT_W-1:0]),
      .cnt    (cnt)
   );

   mt_regbank #(
      .CNT_W(CNT_W), .N_PIN(N_PIN), .N_ALL(N_ALL),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (bus_wr),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .cnt    (cnt),
      .hit    (hit),
      .rdata  (bus_rdata),
      .cnt_ld (cnt_ld),
      .cmp    (cmp),
      .flags  (flags),
      .ien    (ien),
      .ten    (ten),
      .mode   (mode),
      .gpo    (gpo),
      .act    (act)
   );

   for (genvar i = 0; i < N_ALL; i++) begin : g_reg
      mt_slot #(.CNT_W(CNT_W)) u_slot (
         .cnt     (cnt),
         .cmp_val (cmp[i]),
         .cnt_en  (cnt_en),
         .hit     (hit[i])
      );
      if (i < N_PIN) begin : g_pinned
         mt_pin u_pin (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit[i]),
            .act   (act[i]),
            .level (level[i])
         );
         assign pin_out[i] = mode[i] ? level[i] : gpo[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         trig_q <= 1'b0;
      else
         trig_q <= |(hit & ten);
   end

   assign trig = trig_q;
   assign irq  = |(flags & ien);
endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
   parameter int CNT_W  = 16,
   parameter int N_PIN  = 4,
   parameter int N_ALL  = 8,
   parameter int ADDR_W = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cnt_en,
   input logic                  bus_wr,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic [CNT_W-1:0]      cnt,
   input logic [N_ALL-1:0]      hit,
   input logic [N_ALL-1:0]      flags,
   input logic [N_ALL-1:0][1:0] act,
   input logic [N_PIN-1:0]      level,
   input logic                  irq,
   input logic                  trig
);
   p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !(bus_wr && bus_addr == '0)) |=> cnt == $past(cnt) + CNT_W'(1));

   p_cnt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !bus_wr) |=> $stable(cnt));

   p_no_match_halted_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |-> hit == '0);

   p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |=> (flags & $past(hit)) == $past(hit));

   p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> (flags & $past(flags)) == $past(flags));

   p_irq_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(bus_wr));

   p_trig_needs_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> $past(cnt_en));

   p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[0] && act[0] == 2'b11) |=> level[0] != $past(level[0]));

   p_set_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[0] && act[0] == 2'b10) |=> level[0]);
endmodule

bind match_timer mt_checker #(
   .CNT_W(CNT_W), .N_PIN(N_PIN), .N_ALL(N_ALL), .ADDR_W(ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt_en   (cnt_en),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .cnt      (cnt),
   .hit      (hit),
   .flags    (flags),
   .act      (act),
   .level    (level),
   .irq      (irq),
   .trig     (trig)
);

// File: tb/match_timer_test.sv
module match_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [3:0]  pin_out;
   logic        irq;
   logic        trig;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   match_timer uut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_out(pin_out), .irq(irq), .trig(trig)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cnt_en = 1'b0;
      bus_wr = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1;
      bus_addr = a;
      bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic run(input int n);
      cnt_en = 1'b1;
      repeat (n) @(negedge clk);
      cnt_en = 1'b0;
   endtask

   task automatic t_reset();
      logic [15:0] v;
      do_reset();
      wr(2, 16'h00FF);
      wr(4, 16'h000F);
      wr(8, 16'h1234);
      do_reset();
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), v);
         chk("R9 register reads zero", {16'h0, v}, 32'h0);
      end
      chk("R9 pins low", {28'h0, pin_out}, 32'h0);
      chk("R9 irq low", {31'h0, irq}, 32'h0);
      chk("R9 trig low", {31'h0, trig}, 32'h0);
   endtask

   task automatic t_counter();
      logic [15:0] v;
      do_reset();
      wr(0, 16'hFFFE);
      run(3);
      rd(0, v);
      chk("R1 wrap", {16'h0, v}, 32'h0001);
      repeat (5) @(negedge clk);
      rd(0, v);
      chk("R10 counter holds", {16'h0, v}, 32'h0001);
      cnt_en = 1'b1;
      bus_wr = 1'b1;
      bus_addr = 0;
      bus_wdata = 16'h1234;
      @(negedge clk);
      bus_wr = 1'b0;
      cnt_en = 1'b0;
      rd(0, v);
      chk("R1 write wins over count", {16'h0, v}, 32'h1234);
   endtask

   task automatic t_actions();
      logic [15:0] v;
      do_reset();
      wr(4, 16'h000F);
      for (int i = 0; i < 4; i++) wr(4'(8 + i), 16'h0100);
      wr(6, 16'h001B);           // r0 toggle, r1 high, r2 low, r3 none
      wr(0, 16'h00FE);
      run(3);
      chk("R2 pass1 pins", {28'h0, pin_out}, 32'h3);
      wr(6, 16'h00A7);           // r0 toggle, r1 low, r2 high, r3 high
      wr(0, 16'h00FE);
      run(3);
      chk("R2 pass2 pins", {28'h0, pin_out}, 32'hC);
      wr(6, 16'h0013);           // r0 toggle, r1 none, r2 low, r3 none
      wr(0, 16'h00FE);
      run(3);
      chk("R2 pass3 pins", {28'h0, pin_out}, 32'h9);
      rd(1, v);
      chk("R3 pinned flags", {16'h0, v}, 32'h000F);
   endtask

   task automatic t_pinless();
      logic [15:0] v;
      do_reset();
      wr(4, 16'h000F);
      wr(6, 16'hFFFF);
      for (int i = 0; i < 4; i++) wr(4'(8 + i), 16'h0700);
      for (int i = 4; i < 8; i++) wr(4'(8 + i), 16'h0050);
      wr(0, 16'h004E);
      run(3);
      rd(1, v);
      chk("R7 pinless flags", {16'h0, v}, 32'h00F0);
      chk("R7 pins untouched", {28'h0, pin_out}, 32'h0);
   endtask

   task automatic t_flags();
      logic [15:0] v;
      do_reset();
      wr(8, 16'h0020);
      wr(9, 16'h0010);
      wr(0, 16'h0010);
      run(1);
      wr(0, 16'h0020);
      run(1);
      rd(1, v);
      chk("R3 flags set", {16'h0, v}, 32'h0003);
      wr(1, 16'h0000);
      rd(1, v);
      chk("R3 write 0 no effect", {16'h0, v}, 32'h0003);
      wr(0, 16'h0020);
      cnt_en = 1'b1;
      bus_wr = 1'b1;
      bus_addr = 1;
      bus_wdata = 16'h0003;
      @(negedge clk);
      bus_wr = 1'b0;
      cnt_en = 1'b0;
      rd(1, v);
      chk("R4 set beats clear", {16'h0, v}, 32'h0001);
      chk("R5 irq off without enable", {31'h0, irq}, 32'h0);
      wr(2, 16'h0002);
      chk("R5 irq off, enabled flag clear", {31'h0, irq}, 32'h0);
      wr(2, 16'h0001);
      chk("R5 irq on", {31'h0, irq}, 32'h1);
      wr(1, 16'h0001);
      chk("R5 irq off after clear", {31'h0, irq}, 32'h0);
      rd(1, v);
      chk("R3 write 1 clears", {16'h0, v}, 32'h0000);
   endtask

   task automatic t_trigger();
      logic [15:0] v;
      do_reset();
      wr(3, 16'h0021);
      wr(8, 16'h0030);
      wr(13, 16'h0040);
      wr(9, 16'h0050);
      wr(0, 16'h002E);
      run(3);
      chk("R6 trig pulse pinned", {31'h0, trig}, 32'h1);
      @(negedge clk);
      chk("R6 trig one cycle", {31'h0, trig}, 32'h0);
      wr(0, 16'h003E);
      run(3);
      chk("R6 trig pulse pinless", {31'h0, trig}, 32'h1);
      wr(0, 16'h004E);
      run(3);
      chk("R6 no trig when disabled", {31'h0, trig}, 32'h0);
      rd(1, v);
      chk("R6 disabled reg still flags", {15'h0, v[1]}, 32'h1);
   endtask

   task automatic t_gpio();
      logic [15:0] v;
      do_reset();
      wr(5, 16'h0001);
      wr(6, 16'h0003);
      wr(8, 16'h0060);
      chk("R8 pin shows data bit", {28'h0, pin_out}, 32'h1);
      wr(0, 16'h005E);
      run(3);
      rd(1, v);
      chk("R8 flag in data mode", {16'h0, v}, 32'h0001);
      chk("R8 pin unchanged by match", {28'h0, pin_out}, 32'h1);
      wr(5, 16'h0000);
      chk("R8 pin follows data", {28'h0, pin_out}, 32'h0);
      wr(4, 16'h0001);
      chk("R8 level kept updating", {28'h0, pin_out}, 32'h1);
   endtask

   task automatic t_halt();
      logic [15:0] v;
      do_reset();
      wr(4, 16'h0001);
      wr(6, 16'h0003);
      wr(8, 16'h0070);
      wr(0, 16'h0070);
      repeat (5) @(negedge clk);
      rd(1, v);
      chk("R10 no flag while halted", {16'h0, v}, 32'h0);
      chk("R10 no pin change while halted", {28'h0, pin_out}, 32'h0);
      run(1);
      rd(1, v);
      chk("R10 match once enabled", {16'h0, v}, 32'h0001);
      chk("R2 toggle once enabled", {28'h0, pin_out}, 32'h1);
   endtask

   initial begin
      t_reset();
      t_counter();
      t_actions();
      t_pinless();
      t_flags();
      t_trigger();
      t_gpio();
      t_halt();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #4_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule